// File: doc/BRIEF.md
# Real-Time Counter with Coherent Millisecond Snapshot

This block keeps time as a pair of counters: one counts milliseconds and one counts whole seconds. Both advance on a 1 kHz tick-enable input. Software reaches the block through a simple register bus with an address, write data, a write strobe and a read strobe. Read data comes back registered, one cycle after the read strobe.

A timestamp needs two bus reads, so the seconds count could change between them. To keep the pair consistent, every read of the milliseconds register also copies the running seconds count into a read-only shadow register in that same clock edge. Software reads milliseconds first, then the shadow seconds, and computes seconds × 1000 + milliseconds. No other agent may read the milliseconds register between those two reads, because such a read would overwrite the shadow.

Software can also load the live seconds register. A load clears the milliseconds count. The counters never stop, so the values that software reads keep increasing until the seconds counter wraps.

Top module: `rtc_snap`

## Requirements
- R1: After a synchronous active-high reset, the live seconds, shadow seconds and milliseconds registers all read 0, and rdata is 0.
- R2: Each clock cycle with tick high raises the milliseconds count by one. Cycles without tick leave both counters unchanged.
- R3: When a tick arrives while milliseconds is 999, milliseconds returns to 0 and seconds increases by one in the same edge.
- R4: The 32-bit seconds counter wraps from 0xFFFFFFFF to 0 when it is incremented.
- R5: A read of offset 0x10 (milliseconds) returns the milliseconds value from before that edge. In the same edge it copies the seconds value from before that edge into the shadow, even if a tick carries into seconds in that edge. A later read of offset 0x0C returns that copy.
- R6: A write to offset 0x08 loads the seconds counter from wdata and clears milliseconds to 0. The write takes priority over a tick in the same cycle.
- R7: Writes to offset 0x0C (shadow) and offset 0x10 (milliseconds) are ignored. A later read of either register returns its unchanged value.
- R8: A read of any offset other than 0x08, 0x0C or 0x10 returns 0.
- R9: rdata takes the value selected by a read in the edge where rd_en is high. It holds its value in every cycle without rd_en.
- R10: Reads of offsets 0x08 and 0x0C do not change the shadow register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | 1 kHz tick enable, one cycle wide |
| addr | input | 8 | Byte offset of the register being accessed |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |

## Verification
A wrong counter state shows up on the next read of offset 0x08 or 0x10. That read returns a value off from the count of ticks issued since the last load. A bad carry shows up one read after the tick that should have rolled 999 over. A faulty shadow capture shows up as a shadow value that differs from the seconds count sampled at the milliseconds read. The bench targets the cycle where a tick and a milliseconds read coincide, because a late capture returns seconds one too high there. An ignored write that leaks through is caught by reading the register it targeted right afterwards.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam logic [7:0] OFF_SEC_LIVE   = 8'h08;
  localparam logic [7:0] OFF_SEC_SHADOW = 8'h0C;
  localparam logic [7:0] OFF_MSEC       = 8'h10;
endpackage

// File: rtl/rtc_ms_counter.sv
module rtc_ms_counter #(
  parameter int MS_PER_SEC = 1000,
  parameter int MS_W       = $clog2(MS_PER_SEC)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            tick,
  input  logic            clr,
  output logic [MS_W-1:0] ms,
  output logic            carry
);
  localparam logic [MS_W-1:0] MS_MAX = MS_W'(MS_PER_SEC - 1);

  assign carry = tick && (ms == MS_MAX);

  always_ff @(posedge clk) begin
    if (rst || clr) ms <= '0;
    else if (tick)  ms <= carry ? '0 : ms + 1'b1;
  end

  // R2
  ms_step_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && ms != MS_MAX) |=> ms == $past(ms) + 1'b1);
  // R3
  ms_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && !clr && ms == MS_MAX) |=> ms == '0);
  // R2
  ms_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!tick && !clr) |=> $stable(ms));
endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             load,
  input  logic [SEC_W-1:0] din,
  output logic [SEC_W-1:0] sec
);
  always_ff @(posedge clk) begin
    if (rst)       sec <= '0;
    else if (load) sec <= din;
    else if (inc)  sec <= sec + 1'b1;
  end

  // R3
  sec_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> sec == $past(sec) + 1'b1);
  // R6
  sec_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> sec == $past(din));
endmodule

// File: rtl/rtc_shadow.sv
module rtc_shadow #(
  parameter int SEC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture,
  input  logic [SEC_W-1:0] sec_in,
  output logic [SEC_W-1:0] shadow
);
  always_ff @(posedge clk) begin
    if (rst)          shadow <= '0;
    else if (capture) shadow <= sec_in;
  end

  // R5
  shadow_cap_chk: assert property (@(posedge clk) disable iff (rst)
    capture |=> shadow == $past(sec_in));
  // R10
  shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(shadow));
endmodule

// File: rtl/rtc_snap.sv
module rtc_snap #(
  parameter int MS_PER_SEC = 1000,
  parameter int SEC_W      = 32,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rdata
);
  import rtc_pkg::*;

  localparam int MS_W = $clog2(MS_PER_SEC);

  logic [MS_W-1:0]   ms;
  logic              carry;
  logic [SEC_W-1:0]  sec, shadow;
  logic              sel_live, sel_shadow, sel_ms;
  logic              wr_sec, rd_ms;
  logic [DATA_W-1:0] rd_mux;

  assign sel_live   = (addr == ADDR_W'(OFF_SEC_LIVE));
  assign sel_shadow = (addr == ADDR_W'(OFF_SEC_SHADOW));
  assign sel_ms     = (addr == ADDR_W'(OFF_MSEC));
  assign wr_sec     = wr_en && sel_live;
  assign rd_ms      = rd_en && sel_ms;

  rtc_ms_counter #(.MS_PER_SEC(MS_PER_SEC), .MS_W(MS_W)) u_ms (
    .clk(clk), .rst(rst), .tick(tick), .clr(wr_sec), .ms(ms), .carry(carry));

  rtc_sec_counter #(.SEC_W(SEC_W)) u_sec (
    .clk(clk), .rst(rst), .inc(carry), .load(wr_sec),
    .din(wdata[SEC_W-1:0]), .sec(sec));

  rtc_shadow #(.SEC_W(SEC_W)) u_shadow (
    .clk(clk), .rst(rst), .capture(rd_ms), .sec_in(sec), .shadow(shadow));

  always_comb begin
    rd_mux = '0;
    if (sel_live)        rd_mux = DATA_W'(sec);
    else if (sel_shadow) rd_mux = DATA_W'(shadow);
    else if (sel_ms)     rd_mux = DATA_W'(ms);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
  // R8
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !sel_live && !sel_shadow && !sel_ms) |=> rdata == '0);
  // R6
  load_clears_ms_chk: assert property (@(posedge clk) disable iff (rst)
    wr_sec |=> ms == '0);
endmodule

// File: tb/rtc_snap_tb.sv
module rtc_snap_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  rtc_snap u_dut (.clk(clk), .rst(rst), .tick(tick), .addr(addr),
    .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en), .rdata(rdata));

  always #5 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic with_tick);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d; tick = with_tick;
    @(negedge clk); wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 rdata", rdata, 32'h0);
    rd(8'h08, d); check("R1 sec", d, 0);
    rd(8'h0C, d); check("R1 shadow", d, 0);
    rd(8'h10, d); check("R1 ms", d, 0);
  endtask

  task automatic t_count();
    logic [31:0] d;
    ticks(5);
    rd(8'h10, d); check("R2 ms after 5 ticks", d, 5);
    repeat (4) @(negedge clk);
    rd(8'h10, d); check("R2 ms idle", d, 5);
    ticks(994);
    rd(8'h10, d); check("R3 ms at 999", d, 999);
    rd(8'h08, d); check("R3 sec before carry", d, 0);
    ticks(1);
    rd(8'h10, d); check("R3 ms wrapped", d, 0);
    rd(8'h08, d); check("R3 sec carried", d, 1);
  endtask

  task automatic t_load();
    logic [31:0] d;
    ticks(3);
    wr(8'h08, 32'd41, 1'b1);
    rd(8'h10, d); check("R6 ms cleared", d, 0);
    rd(8'h08, d); check("R6 sec loaded", d, 41);
  endtask

  task automatic t_shadow();
    logic [31:0] d;
    ticks(10);
    rd(8'h10, d); check("R5 ms", d, 10);
    wr(8'h08, 32'd77, 1'b0);
    rd(8'h0C, d); check("R5 shadow keeps snapshot", d, 41);
    rd(8'h08, d); check("R10 live read", d, 77);
    rd(8'h0C, d); check("R10 shadow unchanged", d, 41);
    // ms read coinciding with the carrying tick
    wr(8'h08, 32'd5, 1'b0);
    ticks(999);
    @(negedge clk); rd_en = 1'b1; addr = 8'h10; tick = 1'b1;
    @(negedge clk); rd_en = 1'b0; tick = 1'b0;
    check("R5 ms before carry", rdata, 999);
    rd(8'h08, d); check("R5 sec after carry", d, 6);
    rd(8'h0C, d); check("R5 shadow pre-carry", d, 5);
  endtask

  task automatic t_ignored();
    logic [31:0] d;
    wr(8'h0C, 32'd123, 1'b0);
    rd(8'h0C, d); check("R7 shadow write ignored", d, 5);
    wr(8'h10, 32'd456, 1'b0);
    rd(8'h10, d); check("R7 ms write ignored", d, 0);
  endtask

  task automatic t_wrap();
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_FFFF, 1'b0);
    ticks(1000);
    rd(8'h08, d); check("R4 sec wrapped", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h08, 32'd9, 1'b0);
    rd(8'h08, d); check("R9 read", d, 9);
    ticks(3);
    check("R9 rdata held", rdata, 9);
    rd(8'h00, d); check("R8 offset 0x00", d, 0);
    rd(8'h08, d);
    rd(8'h14, d); check("R8 offset 0x14", d, 0);
    rd(8'h04, d); check("R8 offset 0x04", d, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_count();
    t_load();
    t_shadow();
    t_ignored();
    t_wrap();
    t_unmapped();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 50000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule